// File: doc/BRIEF.md
# Performance Counter Bank with Overflow Freeze

The block holds a small bank of wide event counters. One register controls it, one reports its status, and one clears its status. Each counter advances by one on a cycle where its event input is high, its bit in the global enable register is set, and the bank is not frozen. Software reaches every register through a single-cycle write strobe and a combinational read port addressed by `addr`.

A counter overflows when it is stepped from all ones back to zero. That overflow latches a per-counter status bit. The interrupt request is a level signal and stays high while any status bit is set. If freeze-on-interrupt is enabled, the overflow also stops the whole bank, and a mode bit picks how this is done:

- **Clear-enable mode** zeroes the global enable. Software must write the enable register again to restart counting.
- **Flag mode** sets a freeze flag in the status register and leaves the enable alone. Counting restarts as soon as software writes the status value it read into the clear register.

Top module: `pcf_freeze_unit`

## Requirements
- R1: Counter i (address i, 0..3) increments by one per clock in which `event_in[i]` is 1, bit i of the enable register (address 0x08) is 1, and the freeze flag is 0.
- R2: A write to address i loads counter i with `wdata`. The load wins over an event in the same cycle.
- R3: Stepping a counter from all ones wraps it to zero and sets bit i of the status register (address 0x0E) from the next cycle. `irq` is high exactly while any status bit [3:0] is set.
- R4: With bit 0 (freeze enable) of the control register (address 0x09) set and bit 1 (mode) clear, an overflow clears the enable register in the next cycle. Counters then hold until the enable register is written again.
- R5: With freeze enable set and mode set, an overflow sets the freeze flag at status bit 16 in the next cycle and leaves the enable register unchanged. All counters hold while the flag is set.
- R6: The clear register (address 0x10) is write-only and reads as zero. Writing a mask clears the status bits [3:0] where the mask has ones, and mask bit 16 clears the freeze flag. In mode 1, counting resumes in the cycle after the flag clears, with no enable write.
- R7: With freeze enable clear, an overflow still sets its status bit and `irq`, but counting continues.
- R8: The mode and freeze-enable values in force during the overflow cycle decide the action. A control write in that same cycle affects only later overflows.
- R9: An overflow in the same cycle as a clear of its status bit leaves the bit set. An overflow in mode 0 in the same cycle as an enable write leaves the enable register at zero.
- R10: After reset all counters, enable, control and status (including the freeze flag) read zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | 5 | Register address for the read and the write |
| wdata | input | 48 | Write data |
| rdata | output | 48 | Read data for `addr` (combinational) |
| event_in | input | 4 | One event line per counter |
| irq | output | 1 | Level interrupt request, high while any overflow is recorded |

## Verification
The assertions check the following on every cycle:
- An overflow clears the enable register in mode 0 and raises the flag without touching the enable in mode 1.
- Counters hold while the bank is frozen or disabled and no write occurs.
- Each wrap leaves its status bit set.
- `irq` only falls after a clear write.
- The clear register reads zero.

Only the bench scenarios can show the following:
- The exact counts reached.
- Counting resuming in mode 1 with no enable write, and staying stopped in mode 0 until the enable is rewritten.
- The same-cycle orderings: a load against an event, a mode write against an overflow, and a clear or enable write against an overflow.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] A_GEN  = 5'h08;
    localparam logic [ADDR_W-1:0] A_CTL  = 5'h09;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h0E;
    localparam logic [ADDR_W-1:0] A_RST  = 5'h10;
    localparam int FRZ_BIT  = 16;
    localparam int CTL_FZ   = 0;
    localparam int CTL_MODE = 1;
endpackage

// File: rtl/pcf_ctr_bank.sv
module pcf_ctr_bank #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CTR-1:0]         run,
    input  logic [NUM_CTR-1:0]         ev,
    input  logic [NUM_CTR-1:0]         ld,
    input  logic [CTR_W-1:0]           ld_val,
    output logic [NUM_CTR*CTR_W-1:0]   cnt_flat,
    output logic [NUM_CTR-1:0]         wrap
);
    typedef struct packed {
        logic [CTR_W-1:0] cnt;
    } slot_t;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        slot_t s_d, s_q;
        logic  hit;

        always_comb begin
            s_d = s_q;
            hit = 1'b0;
            if (ld[g]) begin
                s_d.cnt = ld_val;
            end else if (run[g] && ev[g]) begin
                s_d.cnt = s_q.cnt + CTR_W'(1);
                hit     = &s_q.cnt;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign cnt_flat[g*CTR_W +: CTR_W] = s_q.cnt;
        assign wrap[g] = hit;
    end
endmodule

// File: rtl/pcf_ctrl.sv
module pcf_ctrl #(
    parameter int NUM_CTR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_gen,
    input  logic               wr_ctl,
    input  logic               wr_rst,
    input  logic [NUM_CTR-1:0] gen_wd,
    input  logic [1:0]         ctl_wd,
    input  logic [NUM_CTR-1:0] rst_mask,
    input  logic               rst_frz,
    input  logic [NUM_CTR-1:0] wrap,
    output logic [NUM_CTR-1:0] gen,
    output logic               fz_en,
    output logic               mode,
    output logic [NUM_CTR-1:0] ovf,
    output logic               frz,
    output logic [NUM_CTR-1:0] run,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_CTR-1:0] gen;
        logic               fz_en;
        logic               mode;
        logic [NUM_CTR-1:0] ovf;
        logic               frz;
    } ctl_t;

    ctl_t st_d, st_q;
    logic any_wrap;

    always_comb begin
        st_d     = st_q;
        any_wrap = |wrap;
        if (wr_gen) st_d.gen = gen_wd;
        if (wr_ctl) begin
            st_d.fz_en = ctl_wd[0];
            st_d.mode  = ctl_wd[1];
        end
        if (wr_rst) begin
            st_d.ovf = st_q.ovf & ~rst_mask;
            if (rst_frz) st_d.frz = 1'b0;
        end
        // new overflows win over a clear in the same cycle
        st_d.ovf = st_d.ovf | wrap;
        // action chosen by the control values in force now, not the ones being written
        if (any_wrap && st_q.fz_en) begin
            if (st_q.mode) st_d.frz = 1'b1;
            else           st_d.gen = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gen   = st_q.gen;
    assign fz_en = st_q.fz_en;
    assign mode  = st_q.mode;
    assign ovf   = st_q.ovf;
    assign frz   = st_q.frz;
    assign run   = st_q.gen & {NUM_CTR{~st_q.frz}};
    assign irq   = |st_q.ovf;
endmodule

// File: rtl/pcf_regif.sv
module pcf_regif #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48
) (
    input  logic                        wr_en,
    input  logic [pcf_pkg::ADDR_W-1:0]  addr,
    input  logic [NUM_CTR*CTR_W-1:0]    cnt_flat,
    input  logic [NUM_CTR-1:0]          gen,
    input  logic                        fz_en,
    input  logic                        mode,
    input  logic [NUM_CTR-1:0]          ovf,
    input  logic                        frz,
    output logic [NUM_CTR-1:0]          ld,
    output logic                        wr_gen,
    output logic                        wr_ctl,
    output logic                        wr_rst,
    output logic [CTR_W-1:0]            rdata
);
    import pcf_pkg::*;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_dec
        assign ld[g] = wr_en && (addr == ADDR_W'(g));
    end

    assign wr_gen = wr_en && (addr == A_GEN);
    assign wr_ctl = wr_en && (addr == A_CTL);
    assign wr_rst = wr_en && (addr == A_RST);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (addr == ADDR_W'(i)) rdata = cnt_flat[i*CTR_W +: CTR_W];
        end
        case (addr)
            A_GEN:  rdata[NUM_CTR-1:0] = gen;
            A_CTL:  begin
                rdata[CTL_FZ]   = fz_en;
                rdata[CTL_MODE] = mode;
            end
            A_STAT: begin
                rdata[NUM_CTR-1:0] = ovf;
                rdata[FRZ_BIT]     = frz;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pcf_freeze_unit.sv
module pcf_freeze_unit #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [pcf_pkg::ADDR_W-1:0]  addr,
    input  logic [CTR_W-1:0]            wdata,
    output logic [CTR_W-1:0]            rdata,
    input  logic [NUM_CTR-1:0]          event_in,
    output logic                        irq
);
    import pcf_pkg::*;

    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic [NUM_CTR-1:0]       wrap, run, ld, gen_en, ovf;
    logic                     wr_gen, wr_ctl, wr_rst, fz_en, mode, frz;

    pcf_regif #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_regif (
        .wr_en(wr_en), .addr(addr), .cnt_flat(cnt_flat), .gen(gen_en),
        .fz_en(fz_en), .mode(mode), .ovf(ovf), .frz(frz), .ld(ld),
        .wr_gen(wr_gen), .wr_ctl(wr_ctl), .wr_rst(wr_rst), .rdata(rdata)
    );

    pcf_ctr_bank #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .run(run), .ev(event_in), .ld(ld),
        .ld_val(wdata), .cnt_flat(cnt_flat), .wrap(wrap)
    );

    pcf_ctrl #(.NUM_CTR(NUM_CTR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_gen(wr_gen), .wr_ctl(wr_ctl),
        .wr_rst(wr_rst), .gen_wd(wdata[NUM_CTR-1:0]),
        .ctl_wd({wdata[CTL_MODE], wdata[CTL_FZ]}),
        .rst_mask(wdata[NUM_CTR-1:0]), .rst_frz(wdata[FRZ_BIT]),
        .wrap(wrap), .gen(gen_en), .fz_en(fz_en), .mode(mode), .ovf(ovf),
        .frz(frz), .run(run), .irq(irq)
    );
endmodule

// File: rtl/pcf_freeze_unit_chk.sv
module pcf_freeze_unit_chk #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [pcf_pkg::ADDR_W-1:0] addr,
    input logic [CTR_W-1:0]           rdata,
    input logic [NUM_CTR-1:0]         wrap,
    input logic [NUM_CTR-1:0]         gen,
    input logic                       fz_en,
    input logic                       mode,
    input logic [NUM_CTR-1:0]         ovf,
    input logic                       frz,
    input logic                       irq,
    input logic                       wr_gen,
    input logic                       wr_rst,
    input logic [NUM_CTR*CTR_W-1:0]   cnt_flat
);
    import pcf_pkg::*;

    p_legacy_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wrap) && fz_en && !mode) |=> (gen == '0));

    p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((gen == '0) && !wr_en) |=> $stable(cnt_flat));

    p_flag_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wrap) && fz_en && mode && !wr_gen) |=> (frz && $stable(gen)));

    p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frz && !wr_en) |=> $stable(cnt_flat));

    p_status_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> ((ovf & $past(wrap)) == $past(wrap)));

    p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_rst) |=> irq);

    always_comb begin
        if (addr == A_RST) begin
            p_clear_reads_zero_r6: assert (rdata == '0);
        end
    end
endmodule

bind pcf_freeze_unit pcf_freeze_unit_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
    .wrap(wrap), .gen(gen_en), .fz_en(fz_en), .mode(mode), .ovf(ovf),
    .frz(frz), .irq(irq), .wr_gen(wr_gen), .wr_rst(wr_rst), .cnt_flat(cnt_flat)
);

// File: tb/pcf_freeze_unit_test.sv
module pcf_freeze_unit_test;
    localparam longint unsigned MASK = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [47:0] wdata = '0;
    logic [47:0] rdata;
    logic [3:0]  event_in = '0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit started = 0;

    longint unsigned m_ctr [4];
    logic [3:0] m_en, m_stat;
    logic       m_fz, m_mode, m_frz;

    always #2 clk = ~clk;

    pcf_freeze_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .event_in(event_in), .irq(irq)
    );

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic longint unsigned m_read(input logic [4:0] a);
        if (a < 5'd4) return m_ctr[a];
        case (a)
            5'h08:   return {60'd0, m_en};
            5'h09:   return {62'd0, m_mode, m_fz};
            5'h0E:   return (longint'(m_frz) << 16) | longint'(m_stat);
            default: return 0;
        endcase
    endfunction

    task automatic m_step();
        logic [3:0] wr;
        logic [3:0] old_en;
        logic old_frz, old_fz, old_mode;
        wr = '0;
        old_en = m_en; old_frz = m_frz; old_fz = m_fz; old_mode = m_mode;
        for (int i = 0; i < 4; i++) begin
            if (wr_en && addr == 5'(i)) m_ctr[i] = longint'(wdata);
            else if (old_en[i] && !old_frz && event_in[i]) begin
                if (m_ctr[i] == MASK) begin m_ctr[i] = 0; wr[i] = 1'b1; end
                else m_ctr[i] = m_ctr[i] + 1;
            end
        end
        if (wr_en && addr == 5'h08) m_en = wdata[3:0];
        if (wr_en && addr == 5'h09) begin m_fz = wdata[0]; m_mode = wdata[1]; end
        if (wr_en && addr == 5'h10) begin
            m_stat = m_stat & ~wdata[3:0];
            if (wdata[16]) m_frz = 1'b0;
        end
        m_stat = m_stat | wr;
        if (wr != 0 && old_fz) begin
            if (old_mode) m_frz = 1'b1;
            else m_en = '0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_ctr[i] = 0;
            m_en = '0; m_stat = '0; m_fz = 0; m_mode = 0; m_frz = 0;
        end else m_step();
    end

    // compare the interrupt level against the model on every clock
    always @(negedge clk) begin
        if (started) check("R3 irq level", longint'(irq), longint'(m_stat != 0));
    end

    task automatic cyc(input logic we, input logic [4:0] a, input logic [47:0] d, input logic [3:0] e);
        wr_en = we; addr = a; wdata = d; event_in = e;
        @(negedge clk);
        wr_en = 0; event_in = '0;
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        addr = a;
        #1;
        check(tag, longint'(rdata), m_read(a));
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 4; i++) rd(5'(i), tag);
        rd(5'h08, tag); rd(5'h09, tag); rd(5'h0E, tag); rd(5'h10, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        // R10 reset state
        rd_all("R10 reset");
        check("R10 irq low", longint'(irq), 0);

        // R1 counting under several event patterns, clear-enable mode
        cyc(1, 5'h08, 48'hF, 0);
        cyc(1, 5'h09, 48'h1, 0);
        for (int k = 0; k < 12; k++) cyc(0, 0, 0, 4'(k));
        rd_all("R1 counts");
        cyc(1, 5'h08, 48'h5, 0);
        for (int k = 0; k < 5; k++) cyc(0, 0, 0, 4'hF);
        rd_all("R1 partial enable");
        cyc(1, 5'h08, 48'hF, 0);

        // R2 load wins over event
        cyc(1, 5'h00, 48'(MASK - 2), 4'h1);
        rd(5'h00, "R2 load");
        check("R2 load value", longint'(rdata), MASK - 2);

        // R3 / R4 overflow in clear-enable mode
        cyc(0, 0, 0, 4'h1);
        cyc(0, 0, 0, 4'h1);
        rd(5'h00, "R3 at max");
        cyc(0, 0, 0, 4'h1);
        rd(5'h0E, "R3 status");
        check("R3 status bit0", longint'(rdata), 1);
        rd(5'h08, "R4 enable cleared");
        check("R4 enable zero", longint'(rdata), 0);
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 4'hF);
        rd_all("R4 held");
        cyc(1, 5'h10, 48'h1, 0);
        check("R6 irq after clear", longint'(irq), 0);
        cyc(0, 0, 0, 4'hF);
        rd_all("R4 still held");
        cyc(1, 5'h08, 48'hF, 0);
        cyc(0, 0, 0, 4'hF);
        rd_all("R4 resumed");

        // R5 / R6 flag mode
        cyc(1, 5'h09, 48'h3, 0);
        cyc(1, 5'h01, 48'(MASK), 0);
        cyc(0, 0, 0, 4'h2);
        rd(5'h0E, "R5 status");
        check("R5 flag and bit1", longint'(rdata), 64'h10002);
        rd(5'h08, "R5 enable kept");
        check("R5 enable F", longint'(rdata), 64'hF);
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 4'hF);
        rd_all("R5 held");
        rd(5'h10, "R6 reads zero");
        check("R6 clear reg zero", longint'(rdata), 0);
        cyc(1, 5'h10, 48'h10002, 0);
        cyc(0, 0, 0, 4'hF);
        rd_all("R6 resumed");
        // clear only the flag: counting resumes, status bit stays, irq stays
        cyc(1, 5'h02, 48'(MASK), 0);
        cyc(0, 0, 0, 4'h4);
        cyc(1, 5'h10, 48'h10000, 0);
        cyc(0, 0, 0, 4'hF);
        rd_all("R6 flag only");
        check("R6 irq remains", longint'(irq), 1);
        cyc(1, 5'h10, 48'hF, 0);

        // R7 freeze disabled
        cyc(1, 5'h09, 48'h0, 0);
        cyc(1, 5'h02, 48'(MASK), 0);
        cyc(0, 0, 0, 4'h4);
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 4'hF);
        rd_all("R7 keeps counting");
        check("R7 irq", longint'(irq), 1);
        cyc(1, 5'h10, 48'hF, 0);

        // R8 control write in the overflow cycle
        cyc(1, 5'h09, 48'h1, 0);
        cyc(1, 5'h03, 48'(MASK), 0);
        cyc(1, 5'h09, 48'h3, 4'h8);
        rd(5'h08, "R8 old mode used");
        check("R8 enable zero", longint'(rdata), 0);
        rd(5'h0E, "R8 no flag");
        check("R8 status", longint'(rdata), 64'h8);

        // R9 same-cycle orderings
        cyc(1, 5'h09, 48'h0, 0);
        cyc(1, 5'h08, 48'hF, 0);
        cyc(1, 5'h00, 48'(MASK), 0);
        cyc(0, 0, 0, 4'h1);
        cyc(1, 5'h00, 48'(MASK), 0);
        cyc(1, 5'h10, 48'h1, 4'h1);
        rd(5'h0E, "R9 set wins");
        check("R9 bit0 kept", longint'(rdata) & 1, 1);
        cyc(1, 5'h09, 48'h1, 0);
        cyc(1, 5'h01, 48'(MASK), 0);
        cyc(1, 5'h08, 48'hF, 4'h2);
        rd(5'h08, "R9 freeze over enable write");
        check("R9 enable zero", longint'(rdata), 0);

        // mixed run in flag mode with servicing
        cyc(1, 5'h10, 48'h1000F, 0);
        cyc(1, 5'h08, 48'hF, 0);
        cyc(1, 5'h09, 48'h3, 0);
        for (int i = 0; i < 4; i++) cyc(1, 5'(i), 48'(MASK - 3 - 2 * i), 0);
        lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (m_stat != 0 && k % 5 == 0)
                cyc(1, 5'h10, 48'(m_read(5'h0E)), lfsr[3:0]);
            else
                cyc(0, 0, 0, lfsr[3:0]);
            if (k % 25 == 0) rd_all("R6 serviced run R1");
        end
        rd_all("R1 final");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule